// File: doc/BRIEF.md
# Voltage-Sense Interrupt Pulse Qualifier

This block takes two comparator flags. Each flag says that a monitored sense input has dropped below its reference. The block turns each flag into an active-low non-maskable interrupt line.

A flag only counts once it has stayed asserted for a programmable run of clock ticks. Brief dips are therefore discarded. Once a channel qualifies, its interrupt stays low for at least a minimum pulse width, and for as long as the dip lasts. A fresh qualified dip during a pulse lengthens the pulse.

Two shared conditions override both channels:
- While the core supply-valid flag is false, both lines are driven low.
- While the master reset is pressed, both lines are driven low. They stay low for a hold time after the master reset is released.

All times are counted in clock ticks. Outputs are registered, so every line lags its cause by one clock.

Top module: `vsense_irq_qualifier`

## Requirements
- R1: A below-reference flag (1 = below) that stays high for fewer than FILT_TICKS consecutive clock samples never drives an interrupt low while no override is active.
- R2: A flag held high for exactly FILT_TICKS samples produces an interrupt pulse (irq_n_o bit = 0) lasting exactly MIN_PULSE_TICKS cycles. The pulse starts one clock after the qualifying sample.
- R3: An interrupt stays low for as long as its flag remains qualified. It is released (back to 1) once both the flag has returned low and the minimum width has elapsed.
- R4: While supply_ok_i is 0, both interrupt outputs are 0 one clock later, whatever the flags are.
- R5: While master_act_i is 1, both interrupt outputs are 0 one clock later.
- R6: After master_act_i falls, both outputs stay 0 for MASTER_HOLD_TICKS further cycles. So a master press of N cycles yields N + MASTER_HOLD_TICKS low cycles.
- R7: A new qualified dip that starts during an active pulse extends the pulse, so that it ends MIN_PULSE_TICKS cycles after the new qualification.
- R8: The channels are independent. Activity on one flag never moves the other channel's output.
- R9: In reset (rst = 1), both outputs are 0 and all timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_i | input | NUM_CH | Comparator flags, 1 = sense input below reference |
| supply_ok_i | input | 1 | Core supply valid, 1 = valid |
| master_act_i | input | 1 | Master reset pressed, 1 = pressed |
| irq_n_o | output | NUM_CH | Active-low interrupt lines, registered |

## Verification
The bench builds the block with a filter of 4 ticks, a minimum pulse of 6 ticks and a master hold of 5 ticks. These short windows let a directed dip land one sample short of the filter threshold. They also let a second dip restart inside a live pulse, since the filter plus the one-cycle gap is shorter than the pulse width. With windows this short, thousands of random flag runs and override toggles hit every timer boundary many times within the cycle budget.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
  // Counter width able to hold the value n (at least one bit).
  function automatic int cnt_w(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int FILT_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic below_i,
  output logic qual_o
);
  localparam int W = vsq_pkg::cnt_w(FILT_TICKS);
  localparam logic [W-1:0] LIM = W'(FILT_TICKS);

  logic [W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)             run_q <= '0;
    else if (!below_i)   run_q <= '0;
    else if (run_q != LIM) run_q <= run_q + 1'b1;
  end

  assign qual_o = (run_q == LIM);

  // R1: a sample above the reference always drops qualification
  p_drop_on_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !below_i |=> !qual_o);
endmodule

// File: rtl/irq_pulse_stretch.sv
module irq_pulse_stretch #(
  parameter int MIN_PULSE_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  output logic act_o
);
  localparam int W = vsq_pkg::cnt_w(MIN_PULSE_TICKS);
  localparam logic [W-1:0] RELOAD = W'(MIN_PULSE_TICKS - 1);

  logic         qual_d;
  logic [W-1:0] rem_q;
  logic         onset;

  assign onset = qual_i && !qual_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_d <= 1'b0;
      rem_q  <= '0;
    end else begin
      qual_d <= qual_i;
      if (onset)             rem_q <= RELOAD;
      else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
    end
  end

  assign act_o = qual_i || (rem_q != '0);

  generate
    if (MIN_PULSE_TICKS >= 2) begin : g_minw
      // R2: a freshly started pulse is never a single cycle
      p_min_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(act_o) |=> act_o);
    end
  endgenerate
endmodule

// File: rtl/irq_override_ctl.sv
module irq_override_ctl #(
  parameter int MASTER_HOLD_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic master_act_i,
  output logic force_o
);
  localparam int W = vsq_pkg::cnt_w(MASTER_HOLD_TICKS);
  localparam logic [W-1:0] HOLD = W'(MASTER_HOLD_TICKS);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)                hold_q <= '0;
    else if (master_act_i)  hold_q <= HOLD;
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign force_o = !supply_ok_i || master_act_i || (hold_q != '0);

  generate
    if (MASTER_HOLD_TICKS >= 1) begin : g_hold
      // R6: the override persists into the first cycle after release
      p_hold_after_release_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(master_act_i) |-> force_o);
    end
  endgenerate
endmodule

// File: rtl/vsense_irq_qualifier.sv
module vsense_irq_qualifier #(
  parameter int NUM_CH            = 2,
  parameter int FILT_TICKS        = 200,
  parameter int MIN_PULSE_TICKS   = 2000,
  parameter int MASTER_HOLD_TICKS = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] below_i,
  input  logic              supply_ok_i,
  input  logic              master_act_i,
  output logic [NUM_CH-1:0] irq_n_o
);
  logic              force_w;
  logic [NUM_CH-1:0] qual_w;
  logic [NUM_CH-1:0] act_w;

  irq_override_ctl #(.MASTER_HOLD_TICKS(MASTER_HOLD_TICKS)) u_ovr (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i),
    .master_act_i(master_act_i), .force_o(force_w)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irq_glitch_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk(clk), .rst(rst), .below_i(below_i[c]), .qual_o(qual_w[c])
      );
      irq_pulse_stretch #(.MIN_PULSE_TICKS(MIN_PULSE_TICKS)) u_pulse (
        .clk(clk), .rst(rst), .qual_i(qual_w[c]), .act_o(act_w[c])
      );

      always_ff @(posedge clk) begin
        if (rst) irq_n_o[c] <= 1'b0;
        else     irq_n_o[c] <= !(act_w[c] || force_w);
      end

      // R3: a qualified dip holds its line low on the next cycle
      p_qual_holds_low_r3: assert property (@(posedge clk) disable iff (rst)
        qual_w[c] |=> !irq_n_o[c]);
    end
  endgenerate

  // R4: no valid supply means every line is active
  p_powerup_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> (irq_n_o == '0));

  // R5: master press drives every line active
  p_master_force_r5: assert property (@(posedge clk) disable iff (rst)
    master_act_i |=> (irq_n_o == '0));
endmodule

// File: tb/vsense_irq_qualifier_tb.sv
module vsense_irq_qualifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int FILT = 4;
  localparam int MINP = 6;
  localparam int MH   = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] below_r = '0;
  logic           ok_r = 1'b0;
  logic           m_r = 1'b0;
  logic [NCH-1:0] irq_n_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsense_irq_qualifier #(
    .NUM_CH(NCH), .FILT_TICKS(FILT),
    .MIN_PULSE_TICKS(MINP), .MASTER_HOLD_TICKS(MH)
  ) u_dut (
    .clk(clk), .rst(rst), .below_i(below_r), .supply_ok_i(ok_r),
    .master_act_i(m_r), .irq_n_o(irq_n_o)
  );

  // Reference built from the requirements: filter run, pulse remainder,
  // master hold remainder; output registered one cycle later.
  int mf[NCH];
  int mrem[NCH];
  bit mqd[NCH];
  int mmh;
  logic [NCH-1:0] exp_n = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        mf[c] = 0; mrem[c] = 0; mqd[c] = 0;
      end
      mmh = 0;
      exp_n = '0;
    end else begin
      bit frc;
      frc = !ok_r || m_r || (mmh != 0);
      for (int c = 0; c < NCH; c++) begin
        bit q;
        q = (mf[c] == FILT);
        exp_n[c] = !(q || (mrem[c] != 0) || frc);
        if (q && !mqd[c]) mrem[c] = MINP - 1;
        else if (mrem[c] != 0) mrem[c] = mrem[c] - 1;
        mqd[c] = q;
        mf[c] = below_r[c] ? (q ? FILT : mf[c] + 1) : 0;
      end
      mmh = m_r ? MH : ((mmh != 0) ? mmh - 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  int low0, low1;

  task automatic tick(input logic [NCH-1:0] b, input logic ok, input logic m,
                      input string tag);
    @(negedge clk);
    if (!rst) chk(irq_n_o === exp_n, tag, irq_n_o, exp_n);
    if (irq_n_o[0] === 1'b0) low0++;
    if (irq_n_o[1] === 1'b0) low1++;
    below_r = b; ok_r = ok; m_r = m;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick('0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(irq_n_o === '0, "R9 reset state", irq_n_o, 0);
    @(negedge clk); rst = 1'b0;

    // R4: supply not yet valid keeps both lines low
    low0 = 0; low1 = 0;
    for (int i = 0; i < 6; i++) tick('0, 1'b0, 1'b0, "R4 powerup");
    tick('0, 1'b1, 1'b0, "R4 powerup");
    chk(low0 == 7 && low1 == 7, "R4 lines held low", low0, 7);
    idle(3, "R4 release");
    chk(irq_n_o === 2'b11, "R4 lines released", irq_n_o, 3);

    // R1: a dip one sample short of the filter
    low0 = 0; low1 = 0;
    for (int i = 0; i < FILT - 1; i++) tick(2'b01, 1'b1, 1'b0, "R1 glitch");
    idle(15, "R1 glitch");
    chk(low0 == 0, "R1 short dip ignored", low0, 0);

    // R2 and R8: exactly FILT samples gives a minimum-width pulse on ch0 only
    low0 = 0; low1 = 0;
    for (int i = 0; i < FILT; i++) tick(2'b01, 1'b1, 1'b0, "R2 pulse");
    idle(20, "R2 pulse");
    chk(low0 == MINP, "R2 min width", low0, MINP);
    chk(low1 == 0, "R8 other channel untouched", low1, 0);

    // R3: long dip on ch1 holds the line for its qualified span
    low0 = 0; low1 = 0;
    for (int i = 0; i < 20; i++) tick(2'b10, 1'b1, 1'b0, "R3 long dip");
    idle(20, "R3 long dip");
    chk(low1 == 21 - FILT, "R3 follows dip", low1, 21 - FILT);
    chk(irq_n_o[1] === 1'b1, "R3 released", irq_n_o[1], 1);
    chk(low0 == 0, "R8 ch0 untouched", low0, 0);

    // R7: a second qualification inside the pulse extends it
    low0 = 0; low1 = 0;
    for (int i = 0; i < FILT; i++) tick(2'b01, 1'b1, 1'b0, "R7 extend");
    tick('0, 1'b1, 1'b0, "R7 extend");
    for (int i = 0; i < FILT; i++) tick(2'b01, 1'b1, 1'b0, "R7 extend");
    idle(25, "R7 extend");
    chk(low0 == FILT + 1 + MINP, "R7 extended pulse", low0, FILT + 1 + MINP);

    // R5 and R6: master press of 3 cycles then hold
    low0 = 0; low1 = 0;
    for (int i = 0; i < 3; i++) tick('0, 1'b1, 1'b1, "R5 master");
    idle(15, "R6 master hold");
    chk(low0 == 3 + MH, "R6 hold length ch0", low0, 3 + MH);
    chk(low1 == 3 + MH, "R5 force ch1", low1, 3 + MH);

    // Random mix checked cycle by cycle against the reference
    for (int i = 0; i < 4000; i++) begin
      logic [NCH-1:0] b;
      logic ok, m;
      int r;
      r = $urandom_range(0, 99);
      ok = (r != 0);
      m  = ($urandom_range(0, 99) < 2);
      b[0] = ($urandom_range(0, 9) < 6) ? below_r[0] : ~below_r[0];
      b[1] = ($urandom_range(0, 9) < 7) ? below_r[1] : ~below_r[1];
      tick(b, ok, m, "R1-mix R2 R3 R4 R5 R6 R7 R8 random");
    end
    idle(3, "R3 random tail");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule